// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block sits beside a processor core and takes in interrupt-vector events from a bank of numbered level lines. When one of the lines goes from low to high and no vector is being held, the block captures that line: it marks itself busy, writes three 64-bit data words and raises a hard-interrupt request. While busy, the request stays up and a fixed vector trap-type code is presented on an index output. The core reads the data words back through a small select-driven read port.

Only one vector is held at a time. Rising lines that arrive while busy are dropped and leave the held words as they are. The held vector is released when any line goes low, or when software asks for the busy flag to be cleared. On every capture the block sends a one-cycle wake pulse so that a halted core resumes. When several lines rise in the same cycle, the lowest-numbered line wins. Each line is compared against its level in the previous cycle, so a line must fall and rise again before it can be captured again.

Top module: `ivl_vector_latch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, hard_req, wake and trap_idx are 0 and data0, data1 and data2 are all zero.
- R2: A line that goes from 0 to 1 while busy is 0 is accepted at that clock edge. From the next cycle on, busy and hard_req are 1 and trap_idx equals the trap-type code (default 0x060).
- R3: On acceptance, data0 is loaded with 0x1f in bits [10:6] and the accepted line number in the low bits (line 2 gives 0x7C2), and data1 and data2 are loaded with zero.
- R4: A line that rises while busy is 1 is ignored: busy stays 1 and data0 keeps its value.
- R5: wake is 1 for exactly the single cycle after an acceptance and is 0 otherwise.
- R6: When any line goes from 1 to 0 while busy is 1, busy, hard_req and trap_idx return to 0 in the next cycle. The data words keep their values.
- R7: sw_clear at 1 while busy is 1 clears busy and hard_req in the next cycle.
- R8: If several lines rise in the same cycle while busy is 0, the lowest-numbered one is the line that gets captured.
- R9: A line that stays high does not cause a new acceptance after the busy flag has been cleared. A new 0-to-1 transition is needed.
- R10: rd_data returns data0, data1 or data2 for rd_sel values 0, 1 and 2 in the same cycle, and returns zero for rd_sel value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_lvl | input | NUM_LINES | Level of each numbered interrupt line |
| sw_clear | input | 1 | Software request to clear the busy flag |
| rd_sel | input | 2 | Read-port word select (0, 1, 2; 3 reads zero) |
| busy | output | 1 | A vector is held |
| hard_req | output | 1 | Hard-interrupt request to the core |
| trap_idx | output | TT_W | Vector trap-type code while busy, else 0 |
| wake | output | 1 | One-cycle pulse to wake a halted core |
| data0 | output | DATA_W | Held data word 0 |
| data1 | output | DATA_W | Held data word 1 |
| data2 | output | DATA_W | Held data word 2 |
| rd_data | output | DATA_W | Read-port data |

## Verification
Acceptance and release both act at the clock edge that first sees the line change. So busy, hard_req, trap_idx, wake and the data words all take their new values one cycle after the stimulus, and rd_data follows rd_sel within the same cycle. The bench changes inputs on the falling edge and reads registered results on the next falling edge, one full cycle later. It reads the read port a short delay after changing rd_sel, with no clock edge in between. The stimulus table lists, for each step, the values expected one cycle after that step is applied, so every row checks exactly the edge it caused.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

  typedef enum logic [1:0] {
    SEL_W0   = 2'd0,
    SEL_W1   = 2'd1,
    SEL_W2   = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  localparam logic [4:0] W0_TAG = 5'h1f;
  localparam int unsigned W0_TAG_LSB = 6;

  // First data word: tag field in [10:6], line number in the low bits
  function automatic logic [63:0] build_word0(input logic [15:0] line);
    logic [63:0] w;
    w = 64'(W0_TAG) << W0_TAG_LSB;
    w = w | 64'(line);
    return w;
  endfunction

endpackage

// File: rtl/ivl_edge_detect.sv
module ivl_edge_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ivl_prio_pick.sv
module ivl_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  // Lowest line number wins
  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_first
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ivl_vec_store.sv
module ivl_vec_store
  import ivl_pkg::*;
#(
  parameter int unsigned       DATA_W = 64,
  parameter int unsigned       IW     = 3,
  parameter int unsigned       TT_W   = 9,
  parameter logic [TT_W-1:0]   TT     = 9'h060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              release_evt,
  input  logic [IW-1:0]     line_idx,
  output logic              busy,
  output logic              wake,
  output logic [TT_W-1:0]   trap_idx,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic [DATA_W-1:0] word2
);
  logic [63:0] w0_next;
  assign w0_next = build_word0(16'(line_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wake  <= 1'b0;
      word0 <= '0;
      word1 <= '0;
      word2 <= '0;
    end else begin
      wake <= accept;
      if (accept) begin
        busy  <= 1'b1;
        word0 <= DATA_W'(w0_next);
        word1 <= '0;
        word2 <= '0;
      end else if (release_evt) begin
        busy <= 1'b0;
      end
    end
  end

  assign trap_idx = busy ? TT : '0;
endmodule

// File: rtl/ivl_vector_latch.sv
module ivl_vector_latch
  import ivl_pkg::*;
#(
  parameter int unsigned     NUM_LINES = 8,
  parameter int unsigned     DATA_W    = 64,
  parameter int unsigned     TT_W      = 9,
  parameter logic [TT_W-1:0] VEC_TT    = 9'h060,
  localparam int unsigned    IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_lvl,
  input  logic                 sw_clear,
  input  logic [1:0]           rd_sel,
  output logic                 busy,
  output logic                 hard_req,
  output logic [TT_W-1:0]      trap_idx,
  output logic                 wake,
  output logic [DATA_W-1:0]    data0,
  output logic [DATA_W-1:0]    data1,
  output logic [DATA_W-1:0]    data2,
  output logic [DATA_W-1:0]    rd_data
);
  logic [NUM_LINES-1:0] rise, fall, grant;
  logic                 any_rise;
  logic [IW-1:0]        pick_idx;
  logic                 accept, release_evt;

  ivl_edge_detect #(.N(NUM_LINES)) i_edge (
    .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .rise(rise), .fall(fall)
  );

  ivl_prio_pick #(.N(NUM_LINES), .IW(IW)) i_pick (
    .req(rise), .any(any_rise), .idx(pick_idx), .grant(grant)
  );

  // Named events for the checker
  assign accept      = any_rise & ~busy;
  assign release_evt = busy & ((|fall) | sw_clear);

  ivl_vec_store #(.DATA_W(DATA_W), .IW(IW), .TT_W(TT_W), .TT(VEC_TT)) i_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .release_evt(release_evt),
    .line_idx(pick_idx), .busy(busy), .wake(wake), .trap_idx(trap_idx),
    .word0(data0), .word1(data1), .word2(data2)
  );

  assign hard_req = busy;

  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      SEL_W0:  rd_data = data0;
      SEL_W1:  rd_data = data1;
      SEL_W2:  rd_data = data2;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ivl_vector_latch_chk.sv
module ivl_vector_latch_chk #(
  parameter int unsigned     NUM_LINES = 8,
  parameter int unsigned     DATA_W    = 64,
  parameter int unsigned     TT_W      = 9,
  parameter logic [TT_W-1:0] VEC_TT    = 9'h060,
  parameter int unsigned     IW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic                 release_evt,
  input logic [NUM_LINES-1:0] grant,
  input logic [IW-1:0]        pick_idx,
  input logic                 busy,
  input logic                 hard_req,
  input logic [TT_W-1:0]      trap_idx,
  input logic                 wake,
  input logic [DATA_W-1:0]    data0,
  input logic [DATA_W-1:0]    data1,
  input logic [DATA_W-1:0]    data2
);
  a_r2_accept_raises: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && hard_req && trap_idx == VEC_TT);

  a_r3_words_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> data0[10:6] == 5'h1f && data1 == '0 && data2 == '0);

  a_r4_busy_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data0));

  a_r5_wake_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wake);

  a_r5_wake_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> busy);

  a_r6_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !busy && !hard_req && trap_idx == '0);

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r8_lowest_captured: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> data0[IW-1:0] == $past(pick_idx));
endmodule

bind ivl_vector_latch ivl_vector_latch_chk #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .TT_W(TT_W), .VEC_TT(VEC_TT), .IW(IW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .release_evt(release_evt),
  .grant(grant), .pick_idx(pick_idx), .busy(busy), .hard_req(hard_req),
  .trap_idx(trap_idx), .wake(wake), .data0(data0), .data1(data1), .data2(data2)
);

// File: tb/test_ivl_vector_latch.sv
module test_ivl_vector_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  line_lvl = '0;
  logic        sw_clear = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic        busy, hard_req, wake;
  logic [8:0]  trap_idx;
  logic [63:0] data0, data1, data2, rd_data;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ivl_vector_latch i_ivl_vector_latch (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .sw_clear(sw_clear),
    .rd_sel(rd_sel), .busy(busy), .hard_req(hard_req), .trap_idx(trap_idx),
    .wake(wake), .data0(data0), .data1(data1), .data2(data2), .rd_data(rd_data)
  );

  // Expected first word restated: tag 31 times 64, plus the line
  function automatic logic [63:0] exp_w0(input int line);
    return 64'(31 * 64 + line);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {lvl[7:0], clr, exp_busy, exp_wake, pad, exp_line[15:0]}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {8'b0000_0100, 1'b0, 1'b1, 1'b1, 1'b0, 16'd2},  // R2 R3 accept line 2
    {8'b0000_0100, 1'b0, 1'b1, 1'b0, 1'b0, 16'd2},  // R5 wake gone
    {8'b0001_0100, 1'b0, 1'b1, 1'b0, 1'b0, 16'd2},  // R4 line 4 ignored
    {8'b0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2},  // R6 line 4 falls
    {8'b0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2},  // R9 held high
    {8'b0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2},  // R6 fall while idle
    {8'b1010_1000, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3},  // R8 lines 3,5,7
    {8'b1010_1000, 1'b1, 1'b0, 1'b0, 1'b0, 16'd3},  // R7 sw clear
    {8'b1010_1001, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0},  // R9 only line 0 new
    {8'b1010_1001, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0},  // R5
    {8'b0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},  // R6
    {8'b1000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'd7}   // R3 top line
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 hard_req", 64'(hard_req), 64'd0);
    check("R1 trap_idx", 64'(trap_idx), 64'd0);
    check("R1 data0", data0, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wake after reset", 64'(wake), 64'd0);

    for (int k = 0; k < NV; k++) begin
      line_lvl = VEC[k][27:20];
      sw_clear = VEC[k][19];
      @(negedge clk);
      sw_clear = 1'b0;
      check($sformatf("R2 busy step %0d", k), 64'(busy), 64'(VEC[k][18]));
      check($sformatf("R2 hard_req step %0d", k), 64'(hard_req), 64'(VEC[k][18]));
      check($sformatf("R2 trap_idx step %0d", k), 64'(trap_idx),
            VEC[k][18] ? 64'h60 : 64'h0);
      check($sformatf("R5 wake step %0d", k), 64'(wake), 64'(VEC[k][17]));
      check($sformatf("R3 data0 step %0d", k), data0, exp_w0(int'(VEC[k][15:0])));
    end

    // R3 R10 read port, line 7 held
    check("R3 data1", data1, 64'd0);
    check("R3 data2", data2, 64'd0);
    rd_sel = 2'd0; #1 check("R10 sel0", rd_data, exp_w0(7));
    rd_sel = 2'd1; #1 check("R10 sel1", rd_data, 64'd0);
    rd_sel = 2'd2; #1 check("R10 sel2", rd_data, 64'd0);
    rd_sel = 2'd3; #1 check("R10 sel3", rd_data, 64'd0);
    rd_sel = 2'd0;

    // R4 rise of several lines while busy
    @(negedge clk);
    line_lvl = 8'b1000_0011;
    @(negedge clk);
    check("R4 busy kept", 64'(busy), 64'd1);
    check("R4 data0 kept", data0, exp_w0(7));

    // R7 clear while idle has no effect, then R1 reset mid-busy
    line_lvl = 8'b0000_0000;
    @(negedge clk);
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
    check("R7 idle clear", 64'(busy), 64'd0);
    line_lvl = 8'b0100_0000;
    @(negedge clk);
    check("R3 line 6", data0, exp_w0(6));
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset data0", data0, 64'd0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule